// File: doc/BRIEF.md
# Multi-Die Flash Status Output Selector

This block sits on the status side of a flash target that holds several dies. Every die presents its own 8-bit status byte. The byte is built live from that die's busy, array-busy, fail, previous-fail, rewrite-advisory and write-protect inputs, and from two pieces of state the block keeps for each die: the last operation type and whether cache mode is active. The block takes decoded command bytes and the row-address byte that follows them. From these it decides whether the 8-bit I/O bus carries array data or a status byte, and which die supplies that byte.

There are two ways to turn status output on. Command 70h reports the die that an address cycle selected most recently. Command 78h is followed by a row address and enables status for that one die only, so that no other die can drive the bus. Status output stays on across any number of read strobes and ends only with command 00h. The status byte is combinational from the die inputs, so the bus follows live changes while chip enable and read enable stay low. The ready/busy pin is the wired-AND of every die's cache-ready flag.

Top module: `flash_status_mux`

## Requirements
- R1: After reset, status output is off: `data_sel` is 0 and `io_out` equals `array_data`.
- R2: Command 70h sets `data_sel` to 1 from the next cycle. `io_out` then carries the status byte of the die most recently selected by an address cycle (die 0 after reset).
- R3: Command 78h sets `data_sel` to 1. `io_out` reads 00h until the following address cycle. If that address names an existing die, `io_out` carries that die's status byte. If it names no die, `io_out` stays 00h.
- R4: Command 00h clears `data_sel`, and `io_out` returns to `array_data`. No other command and no activity on `re_n` clears status output.
- R5: While status output is on, `io_out` follows changes on the die inputs in the same cycle, without any clock edge or read strobe.
- R6: Status byte layout:
  - bit 7 = write-protect input (0 protected, 1 not protected);
  - bit 6 = NOT busy (1 ready to accept data);
  - bit 5 = NOT array-busy;
  - bits 4 and 2 are always 0.
- R7: Bit 0 is the die's current fail input. Bit 1 is its previous-fail input, but only while the die is in cache mode; otherwise bit 1 is 0.
  - Command 15h or 31h puts the most recently selected die into cache mode.
  - Command 10h, 30h or D0h, or a new operation address for that die, takes it out of cache mode.
- R8: Bit 3 is the die's rewrite-advisory input when its last addressed operation was a read (00h). After a program (80h) or erase (60h) address, bit 3 is 0.
- R9: `rb_n` is the AND of status bit 6 over all dies: it is low while any die is busy.
- R10: The row-address byte selects a die through its top $clog2(NUM_DIES) bits. An address cycle after 00h, 80h, 60h or 78h that names an existing die becomes the most recently selected die. An address naming no die leaves that choice unchanged.
- R11: `io_oe` is 1 exactly when `ce_n` and `re_n` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Decoded command byte |
| addr_valid | input | 1 | Row-address byte strobe |
| addr_row | input | ROW_W | Row-address byte; top bits index the die |
| ce_n | input | 1 | Chip enable, active low |
| re_n | input | 1 | Read enable, active low |
| die_wp_n | input | NUM_DIES | Per-die write-protect state (1 = writable) |
| die_busy | input | NUM_DIES | Per-die cache/interface busy |
| die_arr_busy | input | NUM_DIES | Per-die array busy |
| die_fail | input | NUM_DIES | Per-die current operation failed |
| die_fail_prev | input | NUM_DIES | Per-die previous cache operation failed |
| die_rewrite | input | NUM_DIES | Per-die page rewrite advised |
| array_data | input | 8 | Array data for the bus when status is off |
| io_out | output | 8 | I/O bus data |
| io_oe | output | 1 | I/O bus drive enable |
| data_sel | output | 1 | 1 = status on bus, 0 = array data |
| rb_n | output | 1 | Ready/busy pin, low while any die is busy |

## Verification
The bench sweeps all 64 patterns of the six per-die inputs on every die, each die seeing a different pattern, and compares the byte on the bus with one assembled arithmetically. A wrong die index would pass another die's bits. A missing mask would leak the previous-fail or rewrite input onto bits 1 and 3 outside cache mode or after a program. A misplaced field would put an input on a bit that must read 0.

A 78h with an address naming no die is checked to read 00h, which catches a design that clamps the index to a real die. The bench then checks that a following 70h still reports the last valid die, which catches a design that stores the bad index. Status output is held through repeated read strobes and a program command, so a design that drops status on anything other than 00h is caught.

// File: rtl/flash_status_mux.sv
module flash_status_mux #(
  parameter int NUM_DIES = 3,
  parameter int ROW_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_code,
  input  logic                addr_valid,
  input  logic [ROW_W-1:0]    addr_row,
  input  logic                ce_n,
  input  logic                re_n,
  input  logic [NUM_DIES-1:0] die_wp_n,
  input  logic [NUM_DIES-1:0] die_busy,
  input  logic [NUM_DIES-1:0] die_arr_busy,
  input  logic [NUM_DIES-1:0] die_fail,
  input  logic [NUM_DIES-1:0] die_fail_prev,
  input  logic [NUM_DIES-1:0] die_rewrite,
  input  logic [7:0]          array_data,
  output logic [7:0]          io_out,
  output logic                io_oe,
  output logic                data_sel,
  output logic                rb_n
);
  localparam int DIE_W = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1;
  localparam logic [DIE_W:0] NDIES = NUM_DIES[DIE_W:0];

  typedef enum logic [2:0] {P_NONE, P_READ, P_PROG, P_ERASE, P_STAT} pend_t;
  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_PG, OP_ER} op_t;

  pend_t             pend_q;
  logic              stat_en_q, stat_none_q;
  logic [DIE_W-1:0]  sel_die_q, stat_die_q;
  op_t               op_q    [NUM_DIES];
  logic [NUM_DIES-1:0] cache_q;
  logic [NUM_DIES-1:0][7:0] stat_v;

  wire [DIE_W-1:0] addr_die = addr_row[ROW_W-1 -: DIE_W];
  wire             addr_hit = ({1'b0, addr_die} < NDIES);
  wire             addr_use = addr_valid && (pend_q != P_NONE);
  wire             op_addr  = addr_use && addr_hit && (pend_q != P_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= P_NONE;
      stat_en_q   <= 1'b0;
      stat_none_q <= 1'b0;
      sel_die_q   <= '0;
      stat_die_q  <= '0;
    end else if (cmd_valid) begin
      case (cmd_code)
        8'h00: begin stat_en_q <= 1'b0; pend_q <= P_READ; end
        8'h80: pend_q <= P_PROG;
        8'h60: pend_q <= P_ERASE;
        8'h78: begin stat_en_q <= 1'b1; stat_none_q <= 1'b1; pend_q <= P_STAT; end
        8'h70: begin
          stat_en_q   <= 1'b1;
          stat_none_q <= 1'b0;
          stat_die_q  <= sel_die_q;
          pend_q      <= P_NONE;
        end
        default: pend_q <= P_NONE;
      endcase
    end else if (addr_use) begin
      pend_q <= P_NONE;
      if (addr_hit) begin
        sel_die_q <= addr_die;
        if (pend_q == P_STAT) begin
          stat_die_q  <= addr_die;
          stat_none_q <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
    wire me_addr = op_addr && (addr_die == DIE_W'(g));
    wire me_sel  = cmd_valid && (sel_die_q == DIE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_q[g]    <= OP_NONE;
        cache_q[g] <= 1'b0;
      end else if (me_addr) begin
        op_q[g]    <= (pend_q == P_READ) ? OP_RD : (pend_q == P_PROG) ? OP_PG : OP_ER;
        cache_q[g] <= 1'b0;
      end else if (me_sel) begin
        if (cmd_code == 8'h15 || cmd_code == 8'h31) cache_q[g] <= 1'b1;
        else if (cmd_code == 8'h10 || cmd_code == 8'h30 || cmd_code == 8'hD0) cache_q[g] <= 1'b0;
      end
    end

    assign stat_v[g] = {die_wp_n[g], ~die_busy[g], ~die_arr_busy[g], 1'b0,
                        (op_q[g] == OP_RD) & die_rewrite[g], 1'b0,
                        cache_q[g] & die_fail_prev[g], die_fail[g]};
  end

  assign data_sel = stat_en_q;
  assign io_out   = !stat_en_q ? array_data : (stat_none_q ? 8'h00 : stat_v[stat_die_q]);
  assign io_oe    = !ce_n && !re_n;
  assign rb_n     = &(~die_busy);

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_sel |-> io_out == array_data); // R1
  AST_ON_AFTER_70: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h70) |=> data_sel); // R2
  AST_OFF_AFTER_00: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h00) |=> !data_sel); // R4
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_sel && !(cmd_valid && cmd_code == 8'h00)) |=> data_sel); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_sel |-> (io_out[4] == 1'b0 && io_out[2] == 1'b0)); // R6
  AST_RB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|die_busy) |-> !rb_n); // R9
  AST_78_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h78) |=> io_out == 8'h00); // R3
endmodule

// File: tb/sim_flash_status_mux.sv
module sim_flash_status_mux;
  localparam int N = 3;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, addr_valid = 0, ce_n = 1, re_n = 1;
  logic [7:0] cmd_code = 0, addr_row = 0, array_data = 8'hA5;
  logic [N-1:0] wp_n = '1, busy = '0, abusy = '0, fail = '0, fprev = '0, rew = '0;
  logic [7:0] io_out;
  logic io_oe, data_sel, rb_n;
  int n_cmp = 0, n_bad = 0;
  logic done = 0;
  int m_op [N];
  logic [N-1:0] m_cache = '0;

  always #2 clk = ~clk;

  flash_status_mux #(.NUM_DIES(N), .ROW_W(8)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_code, .addr_valid, .addr_row, .ce_n, .re_n,
    .die_wp_n(wp_n), .die_busy(busy), .die_arr_busy(abusy), .die_fail(fail),
    .die_fail_prev(fprev), .die_rewrite(rew), .array_data,
    .io_out, .io_oe, .data_sel, .rb_n);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic adr(input int d);
    @(negedge clk); addr_valid = 1; addr_row = 8'(d << 6);
    @(negedge clk); addr_valid = 0;
  endtask

  function automatic logic [7:0] exp_stat(input int d);
    return {wp_n[d], ~busy[d], ~abusy[d], 1'b0, (m_op[d] == 1) & rew[d], 1'b0,
            m_cache[d] & fprev[d], fail[d]};
  endfunction

  task automatic set_pat(input int p);
    for (int k = 0; k < N; k++) begin
      int v = (p + k * 21) & 63;
      wp_n[k] = v[0]; busy[k] = v[1]; abusy[k] = v[2];
      fail[k] = v[3]; fprev[k] = v[4]; rew[k] = v[5];
    end
  endtask

  task automatic sweep(input int d, input string req);
    for (int p = 0; p < 64; p++) begin
      set_pat(p); #1;
      chk(req, io_out, exp_stat(d));
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) m_op[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 data_sel", {7'd0, data_sel}, 8'd0);
    chk("R1 io", io_out, 8'hA5);
    rst_n = 1;
    cmd(8'h70);
    chk("R2 data_sel", {7'd0, data_sel}, 8'd1);
    sweep(0, "R2/R6 die0 after reset");
    cmd(8'h00); adr(1); m_op[1] = 1;
    chk("R4 off", {7'd0, data_sel}, 8'd0);
    array_data = 8'h3C; #1;
    chk("R4 array", io_out, 8'h3C);
    cmd(8'h70);
    sweep(1, "R5/R6/R8 die1 read");
    cmd(8'h31); m_cache[1] = 1;
    sweep(1, "R7 die1 cache read");
    cmd(8'h80); adr(2); m_op[2] = 2;
    chk("R4 held over 80h", {7'd0, data_sel}, 8'd1);
    cmd(8'h70);
    sweep(2, "R8 die2 program");
    cmd(8'h15); m_cache[2] = 1;
    sweep(2, "R7 die2 cache program");
    cmd(8'h10); m_cache[2] = 0;
    sweep(2, "R7 cache cleared");
    cmd(8'h78);
    chk("R3 blank before addr", io_out, 8'h00);
    adr(1);
    sweep(1, "R3 78h die1");
    cmd(8'h78); adr(3);
    set_pat(63); #1;
    chk("R3 no die", io_out, 8'h00);
    cmd(8'h70);
    sweep(1, "R10 last valid die kept");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); re_n = ~re_n;
      chk("R4 held over re_n", {7'd0, data_sel}, 8'd1);
    end
    cmd(8'h60); adr(0); m_op[0] = 3;
    cmd(8'h70);
    sweep(0, "R8/R10 die0 erase");
    cmd(8'h00);
    chk("R4 off again", io_out, array_data);
    for (int b = 0; b < 8; b++) begin
      busy = 3'(b); #1;
      chk("R9 rb_n", {7'd0, rb_n}, {7'd0, b == 0});
    end
    for (int b = 0; b < 4; b++) begin
      ce_n = b[0]; re_n = b[1]; #1;
      chk("R11 io_oe", {7'd0, io_oe}, {7'd0, b == 0});
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule